// File: doc/BRIEF.md
# DDR Byte-Interface Input FIFO

This block takes a byte-wide source-synchronous bus that moves two bytes per input clock cycle, one on each edge. It pairs each rising-edge byte with the falling-edge byte that follows to form a 16-bit sample word. The words are written into an eight-entry dual-clock FIFO, which a converter clock domain drains at one word per cycle. A frame marker that travels with the data moves the write pointer back to a fixed entry. An output-side strobe places the read pointer a fixed distance behind the write pointer and restarts a small clock divider. Together they give both pointers a known alignment at a moment the system chooses.

Pointers cross between the domains as Gray code. A sticky flag reports any cycle in which the read pointer catches the synchronised write pointer. A transmit-enable input, sampled in the converter domain, forces the registered output word to zero while it is low. Sample words are offset binary and pass through unchanged.

Top module: `ddr_in_fifo`

## Requirements
- R1: The byte present at a rising edge of wrClk is the upper byte and the byte present at the next falling edge is the lower byte of one word. That word is written into the FIFO at the following rising edge, and the first rising edge after reset writes nothing.
- R2: frameIn is sampled only on rising edges of wrClk, together with the upper byte. The word built from that upper byte is written to FIFO entry 0, and the next word goes to entry 1.
- R3: When ostrobe is high at a rising edge of rdClk, the read pointer at the next edge is loaded with the synchronised write pointer minus 4, using 4-bit wrapping pointers. The synchronised value is the write pointer after a wrClk edge, seen through two rdClk register stages.
- R4: divOut is the top bit of a 2-bit counter that advances on every rdClk edge. The edge after ostrobe is sampled high clears the counter, so divOut is low two edges after the strobe.
- R5: When txEnable is low at a rdClk edge, sampleOut is zero after that edge. When it is high, sampleOut takes the FIFO entry addressed by the low 3 bits of the read pointer.
- R6: Without a strobe, the read pointer starts at 12 after reset (4 behind a write pointer of 0, modulo 16) and advances by one on every rdClk edge.
- R7: fifoErr is set at a rdClk edge where the read pointer equals the synchronised write pointer, and stays set until reset.
- R8: Words are offset binary and are carried bit-exact, including 0x0000 and 0xFFFF.
- R9: While reset is held, sampleOut is 0x0000, divOut is 0, fifoErr is 0 and every FIFO entry reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Input data clock; both edges carry a byte |
| wrRstN | input | 1 | Active-low asynchronous reset, write side |
| dataIn | input | 8 | Byte bus, two transfers per wrClk cycle |
| frameIn | input | 1 | Frame start marker, sampled on wrClk rising edges |
| rdClk | input | 1 | Converter clock |
| rdRstN | input | 1 | Active-low asynchronous reset, read side |
| ostrobe | input | 1 | Read-side alignment strobe |
| txEnable | input | 1 | High passes FIFO words, low forces zero output |
| sampleOut | output | 16 | Registered offset-binary sample word |
| divOut | output | 1 | Divided converter clock phase |
| fifoErr | output | 1 | Sticky pointer collision flag |

## Verification
A wrong read pointer shows on sampleOut on the very next rdClk edge as a word from the wrong entry. A lost or misplaced frame realignment shows as a wrong word once the read pointer reaches the affected entries, a few cycles later. A fault in the synchroniser delay or the strobe offset shifts every word after the next strobe by a whole position. A divider that ignores the strobe is visible on divOut two edges later, and a collision check that is missing or not sticky shows on fifoErr in the cycle of the collision or the cycle after it. The bench therefore compares all three outputs with a behavioural model after every converter edge.

// File: rtl/ddrf_pkg.sv
package ddrf_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } ctl_t;
endpackage

// File: rtl/ddrf_ctrl.sv
module ddrf_ctrl
  import ddrf_pkg::*;
#(
  parameter int unsigned DIV_W  = 2,
  parameter int unsigned SYNC_N = 2
) (
  input  logic wrClk,
  input  logic wrRstN,
  input  logic frameQ,
  input  logic rdClk,
  input  logic rdRstN,
  input  logic strobeIn,
  output ctl_t ctl,
  output logic divOut,
  output logic fifoErr
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LAT   = DEPTH / 2;
  localparam logic [PW-1:0] RD_RST = PW'(2 * DEPTH - LAT);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic          wrValid;
  logic [PW-1:0] wPtr, wNext, wGray;

  assign wNext = frameQ ? PW'(1) : wPtr + PW'(1);

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrValid <= 1'b0;
      wPtr    <= '0;
      wGray   <= '0;
    end else begin
      wrValid <= 1'b1;
      if (wrValid) begin
        wPtr  <= wNext;
        wGray <= toGray(wNext);
      end
    end
  end

  // read domain
  logic [PW-1:0]    syncPipe [SYNC_N];
  logic [PW-1:0]    wSync, rPtr;
  logic             strbQ;
  logic [DIV_W-1:0] divCnt;

  assign wSync = fromGray(syncPipe[SYNC_N-1]);

  generate
    for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
      always_ff @(posedge rdClk or negedge rdRstN) begin
        if (!rdRstN) syncPipe[s] <= '0;
        else if (s == 0) syncPipe[s] <= wGray;
        else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      strbQ   <= 1'b0;
      rPtr    <= RD_RST;
      divCnt  <= '0;
      fifoErr <= 1'b0;
    end else begin
      strbQ   <= strobeIn;
      rPtr    <= strbQ ? wSync - PW'(LAT) : rPtr + PW'(1);
      divCnt  <= strbQ ? '0 : divCnt + DIV_W'(1);
      fifoErr <= fifoErr | (rPtr == wSync);
    end
  end

  assign divOut     = divCnt[DIV_W-1];
  assign ctl.wrEn   = wrValid;
  assign ctl.wrAddr = frameQ ? '0 : wPtr[ADDR_W-1:0];
  assign ctl.rdAddr = rPtr[ADDR_W-1:0];
endmodule

// File: rtl/ddrf_datapath.sv
module ddrf_datapath
  import ddrf_pkg::*;
(
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              frameIn,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              txEnable,
  input  ctl_t              ctl,
  output logic              frameQ,
  output logic [WORD_W-1:0] sampleOut
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] hiQ, loQ;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      hiQ    <= '0;
      frameQ <= 1'b0;
    end else begin
      hiQ    <= dataIn;
      frameQ <= frameIn;
    end
  end

  always_ff @(negedge wrClk or negedge wrRstN) begin
    if (!wrRstN) loQ <= '0;
    else loQ <= dataIn;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (ctl.wrEn) begin
      mem[ctl.wrAddr] <= {hiQ, loQ};
    end
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) sampleOut <= '0;
    else sampleOut <= txEnable ? mem[ctl.rdAddr] : '0;
  end
endmodule

// File: rtl/ddr_in_fifo.sv
module ddr_in_fifo
  import ddrf_pkg::*;
#(
  parameter int unsigned DIV_W = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic [BYTE_W-1:0] dataIn,
  input  logic              frameIn,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              ostrobe,
  input  logic              txEnable,
  output logic [WORD_W-1:0] sampleOut,
  output logic              divOut,
  output logic              fifoErr
);
  ctl_t ctl;
  logic frameQ;

  ddrf_datapath u_dp (
    .wrClk(wrClk), .wrRstN(wrRstN), .dataIn(dataIn), .frameIn(frameIn),
    .rdClk(rdClk), .rdRstN(rdRstN), .txEnable(txEnable), .ctl(ctl),
    .frameQ(frameQ), .sampleOut(sampleOut)
  );

  ddrf_ctrl #(.DIV_W(DIV_W), .SYNC_N(2)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .frameQ(frameQ),
    .rdClk(rdClk), .rdRstN(rdRstN), .strobeIn(ostrobe),
    .ctl(ctl), .divOut(divOut), .fifoErr(fifoErr)
  );
endmodule

// File: rtl/ddrf_chk.sv
module ddrf_chk
  import ddrf_pkg::*;
(
  input logic              wrClk,
  input logic              wrRstN,
  input logic              rdClk,
  input logic              rdRstN,
  input logic              strobeIn,
  input logic              txEnable,
  input logic [WORD_W-1:0] sampleOut,
  input logic              divOut,
  input logic              fifoErr,
  input logic              frameQ,
  input ctl_t              ctl
);
  // R2
  frame_to_zero_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (frameQ && ctl.wrEn) |-> (ctl.wrAddr == '0));

  // R2
  frame_next_one_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (frameQ && ctl.wrEn) |=> (ctl.wrEn && (frameQ || ctl.wrAddr == ADDR_W'(1))));

  // R4
  div_restart_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    strobeIn |-> ##2 !divOut);

  // R5
  tx_gate_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !txEnable |=> (sampleOut == '0));

  // R7
  err_sticky_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    fifoErr |=> fifoErr);
endmodule

bind ddr_in_fifo ddrf_chk u_chk (
  .wrClk(wrClk), .wrRstN(wrRstN), .rdClk(rdClk), .rdRstN(rdRstN),
  .strobeIn(ostrobe), .txEnable(txEnable), .sampleOut(sampleOut),
  .divOut(divOut), .fifoErr(fifoErr), .frameQ(frameQ), .ctl(ctl)
);

// File: tb/test_ddr_in_fifo.sv
module test_ddr_in_fifo;
  localparam int PERIOD = 10;
  localparam int Q      = PERIOD / 10;
  localparam int DEPTH  = 8;
  localparam int PMOD   = 16;
  localparam int LAT    = 4;
  localparam int DIVW   = 2;

  logic        wrClk = 0, rdClk = 0, wrRstN = 0, rdRstN = 0;
  logic [7:0]  dataIn = 0;
  logic        frameIn = 0, ostrobe = 0, txEnable = 0;
  logic [15:0] sampleOut;
  logic        divOut, fifoErr;

  ddr_in_fifo i_ddr_in_fifo (
    .wrClk(wrClk), .wrRstN(wrRstN), .dataIn(dataIn), .frameIn(frameIn),
    .rdClk(rdClk), .rdRstN(rdRstN), .ostrobe(ostrobe), .txEnable(txEnable),
    .sampleOut(sampleOut), .divOut(divOut), .fifoErr(fifoErr)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // behavioural reference state
  int mMem [DEPTH];
  int mHi, mLo, mW, mR, ms1, ms2, mDiv;
  bit mValid, mFrame, mStrb;
  int expDout, expErr;

  task automatic modelReset();
    for (int i = 0; i < DEPTH; i++) mMem[i] = 0;
    mHi = 0; mLo = 0; mW = 0; mR = 2 * DEPTH - LAT; ms1 = 0; ms2 = 0; mDiv = 0;
    mValid = 0; mFrame = 0; mStrb = 0; expDout = 0; expErr = 0;
  endtask

  task automatic modelWr();
    if (mValid) begin
      mMem[mFrame ? 0 : (mW % DEPTH)] = mHi * 256 + mLo;
      mW = mFrame ? 1 : (mW + 1) % PMOD;
    end
    mValid = 1; mHi = int'(dataIn); mFrame = frameIn;
  endtask

  task automatic modelRd();
    int nR;
    expDout = txEnable ? mMem[mR % DEPTH] : 0;
    if (mR == ms2) expErr = 1;
    nR   = mStrb ? ((ms2 - LAT) & (PMOD - 1)) : ((mR + 1) % PMOD);
    mDiv = mStrb ? 0 : (mDiv + 1) % (1 << DIVW);
    mR = nR; ms2 = ms1; ms1 = mW; mStrb = ostrobe;
  endtask

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] w, input logic fr, input logic st,
                     input logic te, input logic rs, input string tag);
    dataIn = w[15:8]; frameIn = fr; ostrobe = st; txEnable = te;
    wrRstN = rs; rdRstN = rs;
    if (!rs) modelReset();
    #(Q) wrClk = 1; if (rs) modelWr();
    #(2*Q) dataIn = w[7:0];
    #(Q) rdClk = 1; if (rs) modelRd();
    #(2*Q) wrClk = 0; if (rs) mLo = int'(w[7:0]);
    #(3*Q) rdClk = 0;
    #(Q);
    chk(tag, "sampleOut", int'(sampleOut), expDout);
    chk(tag, "fifoErr", int'(fifoErr), expErr);
    chk(tag, "divOut", int'(divOut), (mDiv >> (DIVW - 1)) & 1);
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'(i * 40503 + 7);
  endfunction

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    modelReset();
    // R9 reset state
    for (int i = 0; i < 3; i++) cyc(pat(i), 0, 0, 1, 0, "R9");
    // R1 R6 free-running stream
    for (int i = 0; i < 24; i++) cyc(pat(i + 100), 0, 0, 1, 1, "R1 R6");
    // R2 frame realigns write side
    cyc(pat(200), 1, 0, 1, 1, "R2");
    for (int i = 0; i < 12; i++) cyc(pat(i + 201), 0, 0, 1, 1, "R2");
    // R3 R4 strobe realigns read side and divider
    cyc(pat(300), 0, 1, 1, 1, "R3 R4");
    for (int i = 0; i < 20; i++) cyc(pat(i + 301), 0, 0, 1, 1, "R3 R4");
    // R8 offset-binary extremes
    for (int i = 0; i < 16; i++) cyc((i % 2) ? 16'hFFFF : 16'h0000, 0, 0, 1, 1, "R8");
    // R5 transmit gating
    for (int i = 0; i < 10; i++) cyc(pat(i + 400), 0, 0, 0, 1, "R5");
    for (int i = 0; i < 6; i++) cyc(pat(i + 410), 0, 0, 1, 1, "R5");
    // R4 double strobe
    cyc(pat(500), 0, 1, 1, 1, "R4");
    cyc(pat(501), 0, 1, 1, 1, "R4");
    for (int i = 0; i < 8; i++) cyc(pat(i + 502), 0, 0, 1, 1, "R4");
    // R9 reset again, then R7 collision storm
    for (int i = 0; i < 2; i++) cyc(pat(i), 0, 0, 1, 0, "R9");
    for (int i = 0; i < 6; i++) cyc(pat(i + 600), 0, 0, 1, 1, "R7");
    chk("R7", "fifoErr clear before storm", int'(fifoErr), 0);
    for (int i = 0; i < 30; i++) cyc(pat(i + 700), (i % 2) == 0, 0, 1, 1, "R7");
    chk("R7", "fifoErr after collision", int'(fifoErr), 1);
    for (int i = 0; i < 4; i++) cyc(pat(i + 800), 0, 0, 1, 1, "R7");
    chk("R7", "fifoErr stays set", int'(fifoErr), 1);
    cyc(pat(0), 0, 0, 1, 0, "R9");
    chk("R9", "fifoErr cleared by reset", int'(fifoErr), 0);
    chk("R9", "sampleOut in reset", int'(sampleOut), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule